// File: doc/BRIEF.md
# Protected Power-of-Two Clock Divider

This block takes a fast source clock and produces a slower system clock: the source rate divided by 2^N, where N is a small select value held in a control register. The divided clock fans out unchanged to four branches: processor, I/O, converter and flash. The clock can also be driven onto a pin. While a static enable is set, the pin carries the divided clock and not its normal value, and this holds during reset as well.

A stray write must not change the ratio by accident, so software has to use a two-write unlock. The first write sets the top bit of the data byte and clears every other bit, which opens a short window. A second write with the top bit clear, captured within four source cycles, loads the low nibble as the new select value. Any other write is ignored.

The output is a gated copy of the source high phase. A new ratio is applied only at the boundary of a divided period, where the counter is reloaded. Because of this, every interval between output rising edges equals either the old period or the new one.

Top module: `clk_prescaler`

## Requirements
- R1: After reset the select value is 0 (divide by 1), the window is closed, and `rd_data` reads 8'h00.
- R2: A write of 8'h80 (bit 7 set, bits 6..0 clear) opens the window. While the window is open, `rd_data[7]` reads 1.
- R3: A write with bit 7 clear, captured on the 1st to 4th source edge after the opening write, loads `wr_data[3:0]` as the select value when that value is 0..8. This write closes the window.
- R4: The window closes by itself after four source cycles. A write with bit 7 clear that is captured on the 5th edge or later leaves the select value unchanged.
- R5: Select code N in 0..8 makes the output rising edges 2^N source cycles apart. `rd_data[3:0]` reads back the code.
- R6: A second-step write of a code from 9 to 15 closes the window and leaves the select value and the output period unchanged.
- R7: While the ratio changes, no interval between output rising edges is shorter than the smaller of the old period and the new period.
- R8: The new period is in force no later than T1+2*T2 after the accepted write, where T1 is the old period and T2 is the new one.
- R9: `clk_cpu`, `clk_io`, `clk_adc` and `clk_flash` carry the same divided clock at all times.
- R10: `pin_out` follows the divided clock when `clkout_en` is 1, and this includes the time reset is held. When `clkout_en` is 0, `pin_out` follows `pin_normal`.
- R11: A write with bit 7 set and any of bits 6..0 set does not open the window.
- R12: A write with bit 7 clear while the window is closed has no effect on the select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 is change-enable, bits 3..0 are the select value |
| rd_data | output | 8 | Readback: bit 7 shows the window is open, bits 3..0 show the select value |
| clkout_en | input | 1 | Static enable for driving the clock onto the pin |
| pin_normal | input | 1 | Value the pin carries when clock-out is off |
| clk_cpu | output | 1 | Divided clock, processor branch |
| clk_io | output | 1 | Divided clock, I/O branch |
| clk_adc | output | 1 | Divided clock, converter branch |
| clk_flash | output | 1 | Divided clock, flash branch |
| pin_out | output | 1 | Pin value: divided clock or the normal value |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a 4-bit select value, a largest code of 8 and a four-cycle window. With these values the whole range from divide-by-1 to divide-by-256 is reachable, and codes 9 to 15 can be written to exercise the reserved case. The window timing can be probed on both sides of its last accepting edge. Switches are run between far-apart ratios, 1 to 256 and 256 to 32, so the shortest interval and the worst-case settling time are checked at their extremes.

// File: rtl/clkps_pkg.sv
package clkps_pkg;

    // Classification of a control-register write
    typedef enum logic [1:0] {
        WR_NONE,
        WR_ARM,
        WR_COMMIT,
        WR_OTHER
    } wr_kind_e;

endpackage

// File: rtl/clkps_unlock.sv
module clkps_unlock #(
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 8,
    parameter int WIN_CYC = 4
) (
    input  logic              src_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] rd_data
);
    import clkps_pkg::*;

    localparam int EN_BIT = DATA_W - 1;
    localparam int WIN_W  = $clog2(WIN_CYC + 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [SEL_W-1:0] sel;
    } ulk_t;

    ulk_t     st_d, st_q;
    wr_kind_e kind;

    always_comb begin
        kind = WR_NONE;
        if (wr_en) begin
            if (wr_data[EN_BIT] && (wr_data[EN_BIT-1:0] == '0))
                kind = WR_ARM;
            else if (!wr_data[EN_BIT] && (st_q.win != '0))
                kind = WR_COMMIT;
            else
                kind = WR_OTHER;
        end

        st_d = st_q;
        if (st_q.win != '0)
            st_d.win = st_q.win - 1'b1;
        case (kind)
            WR_ARM:    st_d.win = WIN_W'(WIN_CYC);
            WR_COMMIT: begin
                st_d.win = '0;
                if (wr_data[SEL_W-1:0] <= SEL_W'(MAX_SEL))
                    st_d.sel = wr_data[SEL_W-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data              = '0;
        rd_data[EN_BIT]      = (st_q.win != '0);
        rd_data[SEL_W-1:0]   = st_q.sel;
    end

    assign sel = st_q.sel;

    // R4: window counter never exceeds its configured length
    assert_win_bound_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
        st_q.win <= WIN_W'(WIN_CYC));

    // R6: the held select value is never a reserved code
    assert_sel_legal_R6: assert property (@(posedge src_clk) disable iff (!rst_n)
        st_q.sel <= SEL_W'(MAX_SEL));

    // R3: the select value only moves while the window was open
    assert_sel_chg_in_win_R3: assert property (@(posedge src_clk) disable iff (!rst_n)
        !$stable(st_q.sel) |-> ($past(st_q.win) != '0));

endmodule

// File: rtl/clkps_divider.sv
module clkps_divider #(
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 8
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             div_clk
);
    localparam int CNT_W = (MAX_SEL > 0) ? MAX_SEL : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] act;
    } div_t;

    div_t st_d, st_q;
    logic gate_q;

    // 2^code - 1 as the counter reload value
    function automatic logic [CNT_W-1:0] reload(input logic [SEL_W-1:0] code);
        logic [CNT_W-1:0] r;
        r = '0;
        for (int i = 0; i < CNT_W; i++)
            if (i < int'(code)) r[i] = 1'b1;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            // period boundary: adopt the latest select value here only
            st_d.act = sel;
            st_d.cnt = reload(sel);
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // gate changes only while the source is low, so the AND cannot glitch
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= (st_q.cnt == '0);
    end

    assign div_clk = src_clk & gate_q;

    // R7: the active ratio changes only at a period boundary
    assert_act_at_boundary_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> ($past(st_q.cnt) == '0));

    // R5: counter stays within the active ratio's range
    assert_cnt_bound_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
        st_q.cnt <= reload(st_q.act));

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 8,
    parameter int WIN_CYC = 4
) (
    input  logic              src_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clkout_en,
    input  logic              pin_normal,
    output logic              clk_cpu,
    output logic              clk_io,
    output logic              clk_adc,
    output logic              clk_flash,
    output logic              pin_out
);
    logic [SEL_W-1:0] sel;
    logic             sys_clk;

    clkps_unlock #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .MAX_SEL(MAX_SEL),
        .WIN_CYC(WIN_CYC)
    ) u_unlock (
        .src_clk(src_clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .sel    (sel),
        .rd_data(rd_data)
    );

    clkps_divider #(
        .SEL_W  (SEL_W),
        .MAX_SEL(MAX_SEL)
    ) u_div (
        .src_clk(src_clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .div_clk(sys_clk)
    );

    assign clk_cpu   = sys_clk;
    assign clk_io    = sys_clk;
    assign clk_adc   = sys_clk;
    assign clk_flash = sys_clk;
    assign pin_out   = clkout_en ? sys_clk : pin_normal;

endmodule

// File: tb/clk_prescaler_tb.sv
module clk_prescaler_tb;
    localparam time TCK = 8ns;

    logic       src_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       clkout_en = 1'b1;
    logic       pin_normal = 1'b0;
    logic       clk_cpu, clk_io, clk_adc, clk_flash, pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(TCK/2) src_clk = ~src_clk;

    clk_prescaler u_dut (
        .src_clk(src_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clkout_en(clkout_en), .pin_normal(pin_normal),
        .clk_cpu(clk_cpu), .clk_io(clk_io), .clk_adc(clk_adc),
        .clk_flash(clk_flash), .pin_out(pin_out)
    );

    // shortest gap between rising edges of the divided clock
    time last_t = 0;
    bit  have_last = 0;
    time min_iv = 0;
    always @(posedge clk_cpu) begin
        if (have_last && (($time - last_t) < min_iv)) min_iv = $time - last_t;
        last_t = $time;
        have_last = 1;
    end

    int pin_edges = 0;
    always @(posedge pin_out) pin_edges++;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // assumes it is called at a falling source edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge src_clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic measure(output int cyc);
        time t0;
        @(posedge clk_cpu); t0 = $time;
        @(posedge clk_cpu); cyc = int'(($time - t0) / TCK);
        @(negedge src_clk);
    endtask

    task automatic check_branches();
        for (int i = 0; i < 6; i++) begin
            @(posedge src_clk); #1;
            check((clk_io == clk_cpu) && (clk_adc == clk_cpu) && (clk_flash == clk_cpu),
                  "R9", {clk_io, clk_adc, clk_flash}, {3{clk_cpu}});
            @(negedge src_clk); #1;
            check((clk_io == clk_cpu) && (clk_adc == clk_cpu) && (clk_flash == clk_cpu),
                  "R9", {clk_io, clk_adc, clk_flash}, {3{clk_cpu}});
        end
    endtask

    // {code, expected divide}
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {8'd3,  16'd8},
        {8'd0,  16'd1},
        {8'd8,  16'd256},
        {8'd5,  16'd32},
        {8'd12, 16'd32},
        {8'd1,  16'd2},
        {8'd15, 16'd2},
        {8'd2,  16'd4}
    };

    initial begin
        #(200000 * TCK);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc, old_div;
        logic [3:0] cur_code;

        // R10: clock reaches the pin while reset is held
        pin_edges = 0;
        repeat (10) @(posedge src_clk);
        check(pin_edges >= 8, "R10", pin_edges, 10);
        @(negedge src_clk); rst_n = 1'b1;
        @(negedge src_clk);
        check(rd_data == 8'h00, "R1", rd_data, 0);
        measure(cyc);
        check(cyc == 1, "R1", cyc, 1);
        check_branches();

        old_div = 1;
        cur_code = 4'd0;
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  code;
            int          exp_div, floor_div;
            logic [3:0]  exp_code;
            code     = VEC[v][23:16];
            exp_div  = int'(VEC[v][15:0]);
            exp_code = (code <= 8) ? code[3:0] : cur_code;
            floor_div = (old_div < exp_div) ? old_div : exp_div;
            min_iv = 64'd1 << 40;
            wr(8'h80);
            check(rd_data[7] == 1'b1, "R2", rd_data[7], 1);
            wr(code);
            check(rd_data == {4'h0, exp_code}, (code <= 8) ? "R3/R5" : "R6",
                  rd_data, {4'h0, exp_code});
            repeat (old_div + 2 * exp_div + 4) @(posedge src_clk);
            @(negedge src_clk);
            check(min_iv >= floor_div * TCK, "R7", min_iv / TCK, floor_div);
            measure(cyc);
            check(cyc == exp_div, (code <= 8) ? "R8/R5" : "R6", cyc, exp_div);
            old_div = exp_div;
            cur_code = exp_code;
        end

        check_branches();

        // R11: malformed arming write, R12: commit with window closed
        wr(8'h83);
        check(rd_data[7] == 1'b0, "R11", rd_data[7], 0);
        wr(8'h05);
        check(rd_data == 8'h02, "R12", rd_data, 2);

        // R4: commit captured on 5th edge is ignored
        wr(8'h80);
        repeat (4) @(negedge src_clk);
        check(rd_data[7] == 1'b0, "R4", rd_data[7], 0);
        wr(8'h06);
        check(rd_data == 8'h02, "R4", rd_data, 2);

        // R3: commit captured on 4th edge is taken
        wr(8'h80);
        repeat (3) @(negedge src_clk);
        wr(8'h01);
        check(rd_data == 8'h01, "R3", rd_data, 1);
        repeat (12) @(posedge src_clk);
        @(negedge src_clk);
        measure(cyc);
        check(cyc == 2, "R3", cyc, 2);

        // R10: pin follows pin_normal when clock-out is off
        clkout_en = 1'b0; pin_normal = 1'b1;
        @(posedge src_clk); #1;
        check(pin_out == 1'b1, "R10", pin_out, 1);
        pin_normal = 1'b0;
        @(posedge src_clk); #1;
        check(pin_out == 1'b0, "R10", pin_out, 0);
        clkout_en = 1'b1;
        pin_edges = 0;
        repeat (8) @(posedge src_clk);
        check(pin_edges == 4, "R10", pin_edges, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule